// File: doc/BRIEF.md
# Post-Load Startup Sequencer

This block takes a device from "configuration image fully loaded" to "user logic running". Once the load-complete indication is seen, it walks through eight numbered phases, 0 to 7, one phase per clock. Each of three user-visible actions has its own phase number: releasing the global output tristate, releasing the open-drain done line, and enabling global writes to RAMs and flip-flops. The end-of-startup flag is always raised in the last phase. The usual setting puts the tristate release at phase 4, the done release at 5 and the write enable at 6, followed by end-of-startup at 7.

The sequencer can also be told to wait. When the lock wait is enabled, it stalls in the lock phase (parameter, default 1) until the clock-manager lock input is high. When the match wait is enabled, it stalls in the match phase (parameter, default 2) until the impedance-calibration match input is high. There is a third kind of stall. Suppose the done line has already been released but reads low, for example because another device on a shared done line still holds it. In that case the sequencer stalls in the write-enable phase until the line reads high. Every flag, once set, stays set until reset.

States: `S_IDLE` (waiting for load-complete), `S_RUN` (runs one phase per clock), `S_WAIT_LOCK`, `S_WAIT_MATCH`, `S_WAIT_DONE` (stalls) and `S_FINISH` (terminal). Transitions:
- `S_IDLE`→`S_RUN` on load-complete, with phase set to 0.
- `S_RUN`→`S_RUN` when no stall condition holds. The current phase executes and the phase number increments.
- `S_RUN`→`S_WAIT_LOCK`, `S_WAIT_MATCH` or `S_WAIT_DONE` on the matching stall condition, with priority in that order. The phase does not execute.
- Each wait state returns to `S_RUN` when its input is sampled high. The same phase is then evaluated again.
- `S_RUN`→`S_FINISH` when phase 7 executes.
- `S_FINISH` holds until reset.

Top module: `startup_seq`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, all four outputs are low.
- R2: While `load_done` is low after reset, no output rises, whatever the other inputs do.
- R3: After `load_done` is first sampled high at clock edge N, and with no stall, phase k executes at edge N+k+1. An output whose phase is k is high from that edge onward, and `startup_end` rises at edge N+8.
- R4: Each of `tri_phase`, `done_phase` and `gwe_phase` is a 3-bit phase number from 0 to 7. Actions that share a phase number rise on the same edge.
- R5: With `wait_lock_en` high, if `lock_in` is low when the lock phase (default 1) is evaluated, that phase stalls. Suppose `lock_in` is first sampled high at edge H, after the evaluation edge. The phase then executes at edge H+1, and later phases shift by the same delay.
- R6: With `wait_lock_en` low, `lock_in` has no effect on timing. With `wait_match_en` low, `match_in` has no effect on timing.
- R7: With `wait_match_en` high, the match phase (default 2) stalls on a low `match_in` in the same way as R5.
- R8: Suppose `done_release` is already high when the write-enable phase is evaluated and `done_in` is low. The phase then stalls until `done_in` is sampled high at edge H, and executes at edge H+1. If the done phase is later than or equal to the write-enable phase, no stall happens.
- R9: Once any output is high it stays high until reset.
- R10: `startup_end` rises only with all other outputs already high or rising on the same edge. After it rises the sequencer never restarts, even if `load_done` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Startup clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_done | input | 1 | Configuration image fully loaded |
| wait_lock_en | input | 1 | Enable the stall on clock-manager lock |
| wait_match_en | input | 1 | Enable the stall on impedance-calibration match |
| lock_in | input | 1 | Clock-manager lock indication |
| match_in | input | 1 | Impedance-calibration match indication |
| done_in | input | 1 | Sampled level of the shared done line |
| tri_phase | input | 3 | Phase number for the tristate release |
| done_phase | input | 3 | Phase number for the done release |
| gwe_phase | input | 3 | Phase number for the global write enable |
| io_release | output | 1 | Global tristate negated, I/Os active |
| done_release | output | 1 | Done line released |
| write_en | output | 1 | Global write enable |
| startup_end | output | 1 | End of startup |

## Verification
Every output is a register inside an action unit. It therefore changes on the very edge at which its phase executes: edge N+k+1 for phase k when there is no stall. Each stall adds the cycles spent waiting plus one, so that the phase can be evaluated again in `S_RUN`. The driver derives the edge of every phase from these rules and pushes one item per edge onto the queue. Each item holds the expected edge number and the set of outputs due to rise. The monitor samples on the falling clock edge, so an output set at edge n is read while the bench edge counter equals n. Every rise it sees is compared against the head of the queue, both in cycle and in output set.

// File: rtl/startup_pkg.sv
package startup_pkg;
    localparam int PHASE_W = 3;
    localparam int NUM_ACT = 4;
    localparam int LAST_PH = (1 << PHASE_W) - 1;

    localparam int ACT_TRI  = 0;
    localparam int ACT_DONE = 1;
    localparam int ACT_GWE  = 2;
    localparam int ACT_EOS  = 3;

    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RUN,
        S_WAIT_LOCK,
        S_WAIT_MATCH,
        S_WAIT_DONE,
        S_FINISH
    } seq_state_t;
endpackage

// File: rtl/startup_gate.sv
module startup_gate
    import startup_pkg::*;
#(
    parameter phase_t LOCK_PH  = phase_t'(1),
    parameter phase_t MATCH_PH = phase_t'(2)
) (
    input  phase_t ph,
    input  phase_t gwe_sel,
    input  logic   wait_lock_en,
    input  logic   lock_in,
    input  logic   wait_match_en,
    input  logic   match_in,
    input  logic   done_rel,
    input  logic   done_in,
    output logic   blk_lock,
    output logic   blk_match,
    output logic   blk_done
);
    always_comb begin
        blk_lock  = (ph == LOCK_PH)  && wait_lock_en  && !lock_in;
        blk_match = (ph == MATCH_PH) && wait_match_en && !match_in;
        blk_done  = (ph == gwe_sel)  && done_rel      && !done_in;
    end
endmodule

// File: rtl/startup_action.sv
module startup_action
    import startup_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fire,
    input  phase_t ph,
    input  phase_t sel,
    output logic   on
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on <= 1'b0;
        end else if (fire && (ph == sel)) begin
            on <= 1'b1;
        end
    end
endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_pkg::*;
#(
    parameter phase_t LOCK_PH  = phase_t'(1),
    parameter phase_t MATCH_PH = phase_t'(2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_done,
    input  logic                wait_lock_en,
    input  logic                wait_match_en,
    input  logic                lock_in,
    input  logic                match_in,
    input  logic                done_in,
    input  logic [PHASE_W-1:0]  tri_phase,
    input  logic [PHASE_W-1:0]  done_phase,
    input  logic [PHASE_W-1:0]  gwe_phase,
    output logic                io_release,
    output logic                done_release,
    output logic                write_en,
    output logic                startup_end
);
    seq_state_t state, state_n;
    phase_t     ph, ph_n;
    logic       blk_lock, blk_match, blk_done;
    logic       fire;
    phase_t     sel_v [NUM_ACT];
    logic       on_v  [NUM_ACT];

    startup_gate #(.LOCK_PH(LOCK_PH), .MATCH_PH(MATCH_PH)) u_gate (
        .ph            (ph),
        .gwe_sel       (gwe_phase),
        .wait_lock_en  (wait_lock_en),
        .lock_in       (lock_in),
        .wait_match_en (wait_match_en),
        .match_in      (match_in),
        .done_rel      (done_release),
        .done_in       (done_in),
        .blk_lock      (blk_lock),
        .blk_match     (blk_match),
        .blk_done      (blk_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ph    <= '0;
        end else begin
            state <= state_n;
            ph    <= ph_n;
        end
    end

    // Next state and phase
    always_comb begin
        state_n = state;
        ph_n    = ph;
        fire    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (load_done) begin
                    state_n = S_RUN;
                    ph_n    = '0;
                end
            end
            S_RUN: begin
                if (blk_lock) begin
                    state_n = S_WAIT_LOCK;
                end else if (blk_match) begin
                    state_n = S_WAIT_MATCH;
                end else if (blk_done) begin
                    state_n = S_WAIT_DONE;
                end else begin
                    fire = 1'b1;
                    if (ph == phase_t'(LAST_PH)) begin
                        state_n = S_FINISH;
                    end else begin
                        ph_n = ph + phase_t'(1);
                    end
                end
            end
            S_WAIT_LOCK:  if (lock_in)  state_n = S_RUN;
            S_WAIT_MATCH: if (match_in) state_n = S_RUN;
            S_WAIT_DONE:  if (done_in)  state_n = S_RUN;
            S_FINISH:     state_n = S_FINISH;
            default:      state_n = S_IDLE;
        endcase
    end

    // Outputs: one sticky unit per action
    always_comb begin
        sel_v[ACT_TRI]  = tri_phase;
        sel_v[ACT_DONE] = done_phase;
        sel_v[ACT_GWE]  = gwe_phase;
        sel_v[ACT_EOS]  = phase_t'(LAST_PH);
    end

    for (genvar i = 0; i < NUM_ACT; i++) begin : g_act
        startup_action u_act (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (fire),
            .ph    (ph),
            .sel   (sel_v[i]),
            .on    (on_v[i])
        );
    end

    assign io_release   = on_v[ACT_TRI];
    assign done_release = on_v[ACT_DONE];
    assign write_en     = on_v[ACT_GWE];
    assign startup_end  = on_v[ACT_EOS];
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk
    import startup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input seq_state_t state,
    input logic       wait_lock_en,
    input logic       wait_match_en,
    input logic       lock_in,
    input logic       done_in,
    input logic       io_release,
    input logic       done_release,
    input logic       write_en,
    input logic       startup_end
);
    // R9
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(io_release) && !$fell(done_release) && !$fell(write_en) && !$fell(startup_end));

    // R10
    eos_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        startup_end |-> (io_release && done_release && write_en));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(write_en) && $past(done_release)) |-> $past(done_in));

    // R6
    lock_wait_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_LOCK) |-> wait_lock_en);

    // R7
    match_wait_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_MATCH) |-> wait_match_en);

    // R5
    lock_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_WAIT_LOCK) && lock_in) |=> (state == S_RUN));
endmodule

bind startup_seq startup_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .wait_lock_en  (wait_lock_en),
    .wait_match_en (wait_match_en),
    .lock_in       (lock_in),
    .done_in       (done_in),
    .io_release    (io_release),
    .done_release  (done_release),
    .write_en      (write_en),
    .startup_end   (startup_end)
);

// File: tb/tb_startup_seq.sv
`timescale 1ns/1ps
module tb_startup_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_done = 1'b0;
    logic       wait_lock_en = 1'b0;
    logic       wait_match_en = 1'b0;
    logic       lock_in = 1'b0;
    logic       match_in = 1'b0;
    logic       done_in = 1'b0;
    logic [2:0] tri_phase = 3'd4;
    logic [2:0] done_phase = 3'd5;
    logic [2:0] gwe_phase = 3'd6;
    logic       io_release, done_release, write_en, startup_end;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        int       at;
        logic [3:0] mask;
        string    req;
    } ev_t;
    ev_t q[$];

    always #4 clk = ~clk;

    startup_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_done     (load_done),
        .wait_lock_en  (wait_lock_en),
        .wait_match_en (wait_match_en),
        .lock_in       (lock_in),
        .match_in      (match_in),
        .done_in       (done_in),
        .tri_phase     (tri_phase),
        .done_phase    (done_phase),
        .gwe_phase     (gwe_phase),
        .io_release    (io_release),
        .done_release  (done_release),
        .write_en      (write_en),
        .startup_end   (startup_end)
    );

    wire [3:0] outs = {startup_end, write_en, done_release, io_release};

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare every rise against the queue head
    logic [3:0] prev = 4'h0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev <= 4'h0;
        end else begin
            if ((outs & ~prev) != 4'h0) begin
                if (q.size() == 0) begin
                    chk("R2 unexpected rise", int'(outs & ~prev), 0);
                end else begin
                    ev_t e;
                    e = q.pop_front();
                    chk({e.req, " cycle"}, cyc, e.at);
                    chk({e.req, " mask"}, int'(outs & ~prev), int'(e.mask));
                end
            end
            prev <= outs;
        end
    end

    function automatic int fw(input int e, input int h);
        return (h <= e) ? e : h + 1;
    endfunction

    task automatic run_case(input string req, input int tp, input int dp, input int gp,
                            input bit len, input bit men,
                            input int lrel, input int mrel, input int drel);
        int c0, e, f, lh, mh, dh;
        rst_n = 1'b0;
        load_done = 1'b0;
        lock_in = 1'b0;
        match_in = 1'b0;
        done_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset outputs", int'(outs), 0);
        tri_phase = tp[2:0];
        done_phase = dp[2:0];
        gwe_phase = gp[2:0];
        wait_lock_en = len;
        wait_match_en = men;
        rst_n = 1'b1;
        lock_in = 1'b1;
        match_in = 1'b1;
        done_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 idle before load", int'(outs), 0);
        c0 = cyc + 1;
        lh = c0 + lrel;
        mh = c0 + mrel;
        dh = c0 + drel;
        lock_in  = (c0 >= lh);
        match_in = (c0 >= mh);
        done_in  = (c0 >= dh);
        load_done = 1'b1;
        f = c0;
        for (int k = 0; k < 8; k++) begin
            logic [3:0] m;
            e = f + 1;
            if (k == 1 && len) e = fw(e, lh);
            if (k == 2 && men) e = fw(e, mh);
            if (k == gp && dp < gp) e = fw(e, dh);
            f = e;
            m = {k == 7, k == gp, k == dp, k == tp};
            if (m != 4'h0) q.push_back('{e, m, req});
        end
        for (int i = 0; i < f - c0 + 6; i++) begin
            @(negedge clk);
            lock_in  = (cyc + 1 >= lh);
            match_in = (cyc + 1 >= mh);
            done_in  = (cyc + 1 >= dh);
        end
        chk({req, " all events seen"}, q.size(), 0);
        chk("R9 flags held", int'(outs), 15);
        load_done = 1'b0;
        repeat (3) @(negedge clk);
        load_done = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 no restart", int'(outs), 15);
        q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R3 R4 usual order
        run_case("R3", 4, 5, 6, 0, 0, 0, 0, 0);
        // R4 shared phase, done line low but no hold since same phase
        run_case("R4", 0, 3, 3, 0, 0, 0, 0, 1000);
        // R5 lock stall
        run_case("R5", 4, 5, 6, 1, 0, 10, 0, 0);
        // R6 lock and match low but waits disabled
        run_case("R6", 2, 5, 6, 0, 0, 1000, 1000, 0);
        // R7 match stall
        run_case("R7", 4, 5, 6, 0, 1, 0, 7, 0);
        // R5 R7 both stalls in sequence
        run_case("R5", 1, 4, 6, 1, 1, 6, 12, 0);
        // R8 done hold
        run_case("R8", 1, 2, 5, 0, 0, 0, 0, 12);
        // R8 write enable before done: no hold
        run_case("R8", 0, 6, 3, 0, 0, 0, 0, 1000);
        // R10 every action in the last phase
        run_case("R10", 7, 7, 7, 0, 0, 0, 0, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule